// File: doc/BRIEF.md
# Super I/O Configuration Gate

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two byte-wide I/O addresses: an index port and a data port directly above it. Configuration is locked after reset. Two key bytes written back to back on the index port open it. One close byte on the same port locks it again. While the gate is open, the host writes a register number to the index port and then reads or writes that register through the data port.

The register space has three kinds of register. A small group of global registers is shared by all devices. One register picks the current logical device. The remaining registers form a per-device bank that holds an activate bit and a window of byte registers. 16-bit settings, such as a base address, use two adjacent window bytes, with the high byte at the lower index.

The top module drives one activate line for each logical device and a flag that shows whether configuration is open.

Top module: `sio_cfg_gate`

## Requirements
- R1: Reset leaves the gate locked (`cfg_open` low), drives every `dev_active` bit low and selects device 0. Device 0 shows up as 0x00 when register 0x07 is read after unlocking.
- R2: Two consecutive index-port writes of 0x87 while locked raise `cfg_open` on the clock edge that captures the second write.
- R3: While locked, any index-port write other than 0x87 cancels a partial unlock. After 0x87, 0x12, 0x87 the gate is still locked.
- R4: An index-port write of 0xAA while open clears `cfg_open` at the next edge and clears the index to 0x00. The device selection, the activate bits and the register contents are all kept.
- R5: While locked, data-port writes change nothing, and reads of either port return 0xFF.
- R6: While open, an index-port write other than 0xAA stores the index, and an index-port read returns it.
- R7: Register 0x07 holds the selected device. A write keeps the low log2(N_DEV) bits, and a read returns them zero-extended.
- R8: Registers 0x20 to 0x2F are global. A value written there reads back the same no matter which device is selected.
- R9: Registers 0x60 to 0x6F form a separate byte window for each device. Adjacent bytes, such as the high byte at 0x60 and the low byte at 0x61, are stored independently.
- R10: Bit 0 of a write to register 0x30 sets or clears `dev_active` of the selected device from the next edge on, and leaves the other devices unchanged. A read returns that bit in bit 0 with all other bits zero.
- R11: While open, a data-port read of an unmapped index returns 0x00 and a write to it has no effect. Reads of other addresses, or cycles with `io_rd` low, return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| cfg_open | output | 1 | Configuration is unlocked |
| dev_active | output | N_DEV | Activate bit of each logical device |

## Verification
A write is captured on the rising edge that ends its bus cycle. Its effect on `cfg_open`, `dev_active` and the stored registers can therefore be seen one cycle after the strobe. A read is combinational and is valid within the cycle that asserts `io_rd`. The bench drives each bus cycle just after a falling edge and samples two nanoseconds later. Each read therefore sees the state left by every earlier write and none left by itself. Flag and activate checks run in an idle cycle that follows the write they depend on.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam logic [7:0] KEY_OPEN     = 8'h87;
    localparam logic [7:0] KEY_CLOSE    = 8'hAA;
    localparam logic [7:0] IDX_DEVSEL   = 8'h07;
    localparam logic [7:0] IDX_ACTIVATE = 8'h30;
    localparam logic [7:0] GLB_FIRST    = 8'h20;
    localparam logic [7:0] BANK_FIRST   = 8'h60;

    typedef enum logic [1:0] {
        GATE_LOCKED,
        GATE_HALF,
        GATE_OPEN
    } gate_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DEVSEL,
        TGT_GLOBAL,
        TGT_ACT,
        TGT_BANK
    } tgt_e;

    typedef struct packed {
        gate_state_e st;
    } gate_s;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic [7:0] idx_wdata,
    output logic       open_o
);
    gate_s gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (idx_we) begin
            unique case (gate_q.st)
                GATE_LOCKED: gate_d.st = (idx_wdata == KEY_OPEN)  ? GATE_HALF : GATE_LOCKED;
                GATE_HALF:   gate_d.st = (idx_wdata == KEY_OPEN)  ? GATE_OPEN : GATE_LOCKED;
                GATE_OPEN:   gate_d.st = (idx_wdata == KEY_CLOSE) ? GATE_LOCKED : GATE_OPEN;
                default:     gate_d.st = GATE_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '{st: GATE_LOCKED};
        else        gate_q <= gate_d;
    end

    assign open_o = (gate_q.st == GATE_OPEN);
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs #(
    parameter int N_REGS = 16,
    localparam int OFF_W = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem_d [N_REGS];
    logic [7:0] mem_q [N_REGS];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[off] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[off];
endmodule

// File: rtl/sio_bank_regs.sv
module sio_bank_regs #(
    parameter int N_DEV  = 8,
    parameter int N_REGS = 16,
    localparam int DEV_W = $clog2(N_DEV),
    localparam int OFF_W = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEV_W-1:0] dev,
    input  logic             reg_we,
    input  logic             act_we,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             act_sel,
    output logic [N_DEV-1:0] act_o
);
    logic [7:0] dev_bytes [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        logic [7:0] regs_d [N_REGS];
        logic [7:0] regs_q [N_REGS];
        logic       act_d, act_q;
        logic       sel;

        assign sel = (dev == DEV_W'(g));

        always_comb begin
            regs_d = regs_q;
            act_d  = act_q;
            if (sel && reg_we) regs_d[off] = wdata;
            if (sel && act_we) act_d = wdata[0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q <= 1'b0;
                for (int i = 0; i < N_REGS; i++) regs_q[i] <= '0;
            end else begin
                act_q  <= act_d;
                regs_q <= regs_d;
            end
        end

        assign act_o[g]     = act_q;
        assign dev_bytes[g] = regs_q[off];
    end

    assign rdata   = dev_bytes[dev];
    assign act_sel = act_o[dev];
endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
    import sio_cfg_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     BASE_ADDR = 16'h0370,
    parameter int              N_DEV     = 8,
    parameter int              GLB_REGS  = 16,
    parameter int              BANK_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_open,
    output logic [N_DEV-1:0]  dev_active
);
    localparam int DEV_W  = $clog2(N_DEV);
    localparam int GLB_W  = $clog2(GLB_REGS);
    localparam int BANK_W = $clog2(BANK_REGS);
    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(1);
    localparam logic [8:0] GLB_END  = {1'b0, GLB_FIRST} + 9'(GLB_REGS);
    localparam logic [8:0] BANK_END = {1'b0, BANK_FIRST} + 9'(BANK_REGS);

    typedef struct packed {
        logic [7:0]       index;
        logic [DEV_W-1:0] ldn;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic              hit_idx, hit_dat;
    logic              idx_we, dat_we;
    logic              gate_open;
    tgt_e              tgt;
    logic [GLB_W-1:0]  glb_off;
    logic [BANK_W-1:0] bank_off;
    logic [7:0]        glb_rdata, bank_rdata;
    logic              act_sel;

    assign hit_idx = (io_addr == IDX_ADDR);
    assign hit_dat = (io_addr == DAT_ADDR);
    assign idx_we  = io_wr && hit_idx;
    assign dat_we  = io_wr && hit_dat && gate_open;

    sio_unlock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (idx_we),
        .idx_wdata (io_wdata),
        .open_o    (gate_open)
    );

    // Index decode: device select and activate take priority over the windows
    always_comb begin
        tgt = TGT_NONE;
        if (ctl_q.index == IDX_DEVSEL)
            tgt = TGT_DEVSEL;
        else if (ctl_q.index == IDX_ACTIVATE)
            tgt = TGT_ACT;
        else if ({1'b0, ctl_q.index} >= {1'b0, GLB_FIRST} && {1'b0, ctl_q.index} < GLB_END)
            tgt = TGT_GLOBAL;
        else if ({1'b0, ctl_q.index} >= {1'b0, BANK_FIRST} && {1'b0, ctl_q.index} < BANK_END)
            tgt = TGT_BANK;
    end

    assign glb_off  = GLB_W'(ctl_q.index - GLB_FIRST);
    assign bank_off = BANK_W'(ctl_q.index - BANK_FIRST);

    always_comb begin
        ctl_d = ctl_q;
        if (idx_we && gate_open) begin
            if (io_wdata == KEY_CLOSE) ctl_d.index = '0;
            else                       ctl_d.index = io_wdata;
        end
        if (dat_we && tgt == TGT_DEVSEL) ctl_d.ldn = io_wdata[DEV_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sio_global_regs #(.N_REGS(GLB_REGS)) u_glb (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dat_we && tgt == TGT_GLOBAL),
        .off   (glb_off),
        .wdata (io_wdata),
        .rdata (glb_rdata)
    );

    sio_bank_regs #(.N_DEV(N_DEV), .N_REGS(BANK_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev     (ctl_q.ldn),
        .reg_we  (dat_we && tgt == TGT_BANK),
        .act_we  (dat_we && tgt == TGT_ACT),
        .off     (bank_off),
        .wdata   (io_wdata),
        .rdata   (bank_rdata),
        .act_sel (act_sel),
        .act_o   (dev_active)
    );

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && gate_open) begin
            if (hit_idx) begin
                io_rdata = ctl_q.index;
            end else if (hit_dat) begin
                unique case (tgt)
                    TGT_DEVSEL: io_rdata = 8'(ctl_q.ldn);
                    TGT_ACT:    io_rdata = {7'b0, act_sel};
                    TGT_GLOBAL: io_rdata = glb_rdata;
                    TGT_BANK:   io_rdata = bank_rdata;
                    default:    io_rdata = 8'h00;
                endcase
            end
        end
    end

    assign cfg_open = gate_open;
endmodule

// File: rtl/sio_cfg_gate_chk.sv
module sio_cfg_gate_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0370,
    parameter int          N_DEV     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_open,
    input logic [N_DEV-1:0]  dev_active
);
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(BASE_ADDR) + ADDR_W'(1);

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && io_addr == A_IDX && io_wdata == 8'h87)); // R2

    AST_BAD_KEY_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr && io_addr == A_IDX && io_wdata != 8'h87) |=> !cfg_open); // R3

    AST_CLOSE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && io_addr == A_IDX && io_wdata == 8'hAA) |=> !cfg_open); // R4

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && (io_addr == A_IDX || io_addr == A_DAT)) |-> io_rdata == 8'hFF); // R5

    AST_LOCKED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr) |=> $stable(dev_active)); // R5

    AST_ONE_DEVICE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dev_active ^ $past(dev_active)) <= 1); // R10

    AST_FOREIGN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr != A_IDX && io_addr != A_DAT) |-> io_rdata == 8'hFF); // R11
endmodule

bind sio_cfg_gate sio_cfg_gate_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .N_DEV(N_DEV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cfg_open   (cfg_open),
    .dev_active (dev_active)
);

// File: tb/sio_cfg_gate_bench.sv
module sio_cfg_gate_bench;
    localparam logic [1:0]  OP_WR  = 2'd0;
    localparam logic [1:0]  OP_RD  = 2'd1;
    localparam logic [1:0]  OP_OPN = 2'd2;
    localparam logic [1:0]  OP_ACT = 2'd3;
    localparam logic [15:0] AI = 16'h0370;
    localparam logic [15:0] AD = 16'h0371;
    localparam logic [15:0] AX = 16'h0372;
    localparam int NV = 52;

    // {op, address, write data, expected, requirement number}
    localparam logic [41:0] VEC [NV] = '{
        {OP_RD,  AI, 8'h00, 8'hFF, 8'd5},   // R5 locked index read
        {OP_WR,  AD, 8'h55, 8'h00, 8'd5},   // R5 locked data write
        {OP_WR,  AI, 8'h87, 8'h00, 8'd3},   // R3
        {OP_WR,  AI, 8'h12, 8'h00, 8'd3},
        {OP_WR,  AI, 8'h87, 8'h00, 8'd3},
        {OP_OPN, AI, 8'h00, 8'h00, 8'd3},   // R3 still locked
        {OP_WR,  AI, 8'h87, 8'h00, 8'd2},   // R2
        {OP_OPN, AI, 8'h00, 8'h01, 8'd2},
        {OP_WR,  AI, 8'h07, 8'h00, 8'd1},   // R1 device 0 after reset
        {OP_RD,  AD, 8'h00, 8'h00, 8'd1},
        {OP_RD,  AI, 8'h00, 8'h07, 8'd6},   // R6 index readback
        {OP_WR,  AD, 8'h0B, 8'h00, 8'd7},   // R7 truncated to 3
        {OP_RD,  AD, 8'h00, 8'h03, 8'd7},
        {OP_WR,  AI, 8'h60, 8'h00, 8'd9},   // R9 split word
        {OP_WR,  AD, 8'h12, 8'h00, 8'd9},
        {OP_WR,  AI, 8'h61, 8'h00, 8'd9},
        {OP_WR,  AD, 8'h34, 8'h00, 8'd9},
        {OP_RD,  AD, 8'h00, 8'h34, 8'd9},
        {OP_WR,  AI, 8'h60, 8'h00, 8'd9},
        {OP_RD,  AD, 8'h00, 8'h12, 8'd9},
        {OP_WR,  AI, 8'h30, 8'h00, 8'd10},  // R10 activate device 3
        {OP_WR,  AD, 8'hFF, 8'h00, 8'd10},
        {OP_ACT, AI, 8'h00, 8'h08, 8'd10},
        {OP_RD,  AD, 8'h00, 8'h01, 8'd10},
        {OP_WR,  AI, 8'h07, 8'h00, 8'd9},   // R9 device 1 bank separate
        {OP_WR,  AD, 8'h01, 8'h00, 8'd9},
        {OP_WR,  AI, 8'h60, 8'h00, 8'd9},
        {OP_RD,  AD, 8'h00, 8'h00, 8'd9},
        {OP_WR,  AI, 8'h30, 8'h00, 8'd10},
        {OP_RD,  AD, 8'h00, 8'h00, 8'd10},
        {OP_WR,  AI, 8'h25, 8'h00, 8'd8},   // R8 global shared
        {OP_WR,  AD, 8'hA5, 8'h00, 8'd8},
        {OP_WR,  AI, 8'h07, 8'h00, 8'd8},
        {OP_WR,  AD, 8'h03, 8'h00, 8'd8},
        {OP_WR,  AI, 8'h25, 8'h00, 8'd8},
        {OP_RD,  AD, 8'h00, 8'hA5, 8'd8},
        {OP_WR,  AI, 8'h50, 8'h00, 8'd11},  // R11 unmapped
        {OP_WR,  AD, 8'h77, 8'h00, 8'd11},
        {OP_RD,  AD, 8'h00, 8'h00, 8'd11},
        {OP_RD,  AX, 8'h00, 8'hFF, 8'd11},
        {OP_WR,  AI, 8'hAA, 8'h00, 8'd4},   // R4 close
        {OP_OPN, AI, 8'h00, 8'h00, 8'd4},
        {OP_RD,  AD, 8'h00, 8'hFF, 8'd5},   // R5 locked data read
        {OP_WR,  AD, 8'h00, 8'h00, 8'd5},
        {OP_ACT, AI, 8'h00, 8'h08, 8'd5},
        {OP_WR,  AI, 8'h87, 8'h00, 8'd4},   // R4 state kept
        {OP_WR,  AI, 8'h87, 8'h00, 8'd4},
        {OP_RD,  AI, 8'h00, 8'h00, 8'd4},
        {OP_WR,  AI, 8'h30, 8'h00, 8'd4},
        {OP_RD,  AD, 8'h00, 8'h01, 8'd4},
        {OP_WR,  AD, 8'h00, 8'h00, 8'd10},  // R10 deactivate
        {OP_ACT, AI, 8'h00, 8'h00, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_open;
    logic [7:0]  dev_active;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sio_cfg_gate u_sio_cfg_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .cfg_open   (cfg_open),
        .dev_active (dev_active)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
        #2;
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 16'h0000, 8'h00);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check8("R1 open flag in reset", {7'b0, cfg_open}, 8'h00);
        check8("R1 activate in reset", dev_active, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [41:0] e;
            string       tag;
            e   = VEC[i];
            tag = $sformatf("R%0d vec %0d", e[7:0], i);
            case (e[41:40])
                OP_WR: bus(1'b1, 1'b0, e[39:24], e[23:16]);
                OP_RD: begin
                    bus(1'b0, 1'b1, e[39:24], 8'h00);
                    check8(tag, io_rdata, e[15:8]);
                end
                OP_OPN: begin
                    idle();
                    check8(tag, {7'b0, cfg_open}, e[15:8]);
                end
                default: begin
                    idle();
                    check8(tag, dev_active, e[15:8]);
                end
            endcase
        end

        // R11: data port with io_rd low returns idle value
        bus(1'b0, 1'b0, AD, 8'h00);
        check8("R11 no read strobe", io_rdata, 8'hFF);

        // R1: reset in mid-run restores defaults
        bus(1'b1, 1'b0, AI, 8'h30);
        bus(1'b1, 1'b0, AD, 8'h01);
        idle();
        check8("R10 reactivate before reset", dev_active, 8'h08);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check8("R1 open flag after reset", {7'b0, cfg_open}, 8'h00);
        check8("R1 activate after reset", dev_active, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        bus(1'b1, 1'b0, AI, 8'h87);
        bus(1'b1, 1'b0, AI, 8'h87);
        bus(1'b1, 1'b0, AI, 8'h07);
        bus(1'b0, 1'b1, AD, 8'h00);
        check8("R1 device select after reset", io_rdata, 8'h00);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule